// File: doc/BRIEF.md
# Home Conflict Sequencer

This block sits at the home node of one cache line in a four-node source-snooping coherence fabric. Each requester first broadcasts its request. After collecting every peer reply it sends home a second-phase message: a READ when no cache supplied the line, or a CNCL when a cache did. That message carries the sender's node number and a four-bit vector of the nodes it saw competing for the same line. A message with no conflicts is completed at once: a canceller gets an ACK, and a reader gets the line from memory.

When messages report conflicts, the block merges every vector it receives into one membership set, because a party may fail to notice a conflict that another party did see. It then builds a forwarding chain. A conflicted CNCL names the winner. If only READs arrive, the earliest queued READ becomes the winner and gets memory data. The other parties follow in the order their messages arrive. Each party that has a successor gets a transfer order naming that successor. Each party other than the winner gets a wait order naming its predecessor. There is never a retry.

A memory read is launched speculatively when the initial broadcast is observed, so the data is usually already held when the READ arrives. Outgoing orders leave one per cycle over a valid/ready handshake.

Top module: `home_conflict_sequencer`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` and `mem_rd_req` are low and `msg_ready` is high.
- R2: A CNCL with an empty conflict vector, from a node that is not part of an open conflict, produces one ACK (`out_kind` 0) addressed to the sender.
- R3: A READ with an empty conflict vector, from a node that is not part of an open conflict, produces one DATA order (`out_kind` 1) to the sender, carrying the memory word on `out_data`. A DATA order is presented only once the memory word is held.
- R4: A pulse on `req_seen` issues a one-cycle memory read request. A later conflict-free READ is then answered in the cycle after its acceptance, with no further memory request.
- R5: Membership is the union of all received vectors plus the senders. A node that reports an empty vector but has been named by another node is handled as a conflicted party.
- R6: The first conflicted CNCL of a conflict makes its sender the winner. The winner gets a transfer order (`out_kind` 2, `out_peer` = successor) naming the first queued party, as soon as that party is known.
- R7: If every member has reported and no CNCL has arrived, the earliest queued READ becomes the winner and gets a DATA order, emitted after the orders caused by the last arrival.
- R8: Conflicted parties that are not the winner are queued in arrival order. Each gets a wait order (`out_kind` 3, `out_peer` = predecessor). Its predecessor gets a transfer order naming it, and that transfer order comes first. The last party gets no transfer order.
- R9: The orders for an arriving party are emitted as soon as its predecessor is known. They do not wait for the remaining members to report.
- R10: Once every member has reported and a winner is fixed, the conflict closes. A following message with an empty vector from any node is treated as conflict-free.
- R11: Orders leave one per cycle, in generation order. While `out_valid` is high and `out_ready` is low, `out_valid` and all order fields hold steady.
- R12: `msg_ready` drops when the order buffer has fewer free slots than one message can generate. No order is lost under any amount of backpressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_seen | input | 1 | Initial broadcast for the line observed; starts a speculative fetch |
| msg_valid | input | 1 | Second-phase message present |
| msg_ready | output | 1 | Message accepted when high together with msg_valid |
| msg_is_cncl | input | 1 | 1 = CNCL, 0 = READ |
| msg_src | input | 2 | Sending node number |
| msg_conflicts | input | 4 | One bit per node seen competing |
| mem_rd_req | output | 1 | One-cycle memory read request |
| mem_rd_valid | input | 1 | Memory word returned this cycle |
| mem_rd_data | input | 32 | Returned memory word |
| out_valid | output | 1 | Order present |
| out_ready | input | 1 | Order taken when high together with out_valid |
| out_kind | output | 2 | 0 ACK, 1 DATA, 2 transfer, 3 wait |
| out_dst | output | 2 | Node that receives the order |
| out_peer | output | 2 | Successor for a transfer, predecessor for a wait, else 0 |
| out_data | output | 32 | Memory word for DATA, else 0 |

## Verification
The bench targets a node that reports an empty vector after being named. A design that ignored the union would send that node memory data and leave a second holder of the line. It also targets conflicts made only of READs, where a design that never promoted a winner would leave every reader waiting forever. It checks that a transfer order reaches the predecessor as soon as a party arrives, and does not wait for the remaining members, and it varies arrival order and CNCL position at random. It also checks that the speculative fetch removes the memory wait, and that stalled orders are neither dropped nor reordered once the order buffer fills.

// File: rtl/hcs_pkg.sv
// Shared constants and types for the home conflict sequencer.
package hcs_pkg;
    localparam int unsigned NODE_CNT = 4;
    localparam int unsigned ID_W     = $clog2(NODE_CNT);
    localparam int unsigned MAX_EMIT = 3;
    localparam int unsigned EMIT_W   = $clog2(MAX_EMIT + 1);

    typedef enum logic [1:0] {
        K_ACK  = 2'd0,
        K_DATA = 2'd1,
        K_XFR  = 2'd2,
        K_WAIT = 2'd3
    } msg_kind_e;

    typedef struct packed {
        msg_kind_e       kind;
        logic [ID_W-1:0] dst;
        logic [ID_W-1:0] peer;
    } out_msg_t;
endpackage

// File: rtl/hcs_episode.sv
// Conflict bookkeeping for one line.
// Takes one second-phase message per cycle and returns up to MAX_EMIT
// orders in the order they must be sent.
// Assumes each node reports at most once per conflict, and that the
// caller only accepts a message when MAX_EMIT buffer slots are free.
module hcs_episode
    import hcs_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          acc,
    input  logic                          is_cncl,
    input  logic [ID_W-1:0]               src,
    input  logic [NODE_CNT-1:0]           lst,
    output out_msg_t [MAX_EMIT-1:0]       emit,
    output logic [EMIT_W-1:0]             emit_cnt
);
    localparam int unsigned CNT_W = $clog2(NODE_CNT + 1);

    logic [NODE_CNT-1:0]            members, reported;
    logic                           wvalid;
    logic [ID_W-1:0]                wid;
    logic [NODE_CNT-1:0][ID_W-1:0]  q;
    logic [CNT_W-1:0]               qcnt;

    logic [NODE_CNT-1:0]            mem_n, rep_n;
    logic                           wv_n;
    logic [ID_W-1:0]                wid_n;
    logic [NODE_CNT-1:0][ID_W-1:0]  q_n;
    logic [CNT_W-1:0]               qc_n;

    function automatic out_msg_t mk(msg_kind_e k, logic [ID_W-1:0] d, logic [ID_W-1:0] p);
        out_msg_t m;
        m.kind = k;
        m.dst  = d;
        m.peer = p;
        return m;
    endfunction

    // Decide the orders for the accepted message and the next conflict state.
    always_comb begin
        logic [NODE_CNT-1:0] sbit, lm;
        logic [CNT_W-1:0]    qm1;
        logic [ID_W-1:0]     pred;
        logic [EMIT_W-1:0]   ec;
        mem_n = members;
        rep_n = reported;
        wv_n  = wvalid;
        wid_n = wid;
        q_n   = q;
        qc_n  = qcnt;
        emit  = '0;
        ec    = '0;
        sbit  = NODE_CNT'(1) << src;
        lm    = lst & ~sbit;
        qm1   = qcnt - 1'b1;
        pred  = q[qm1[ID_W-1:0]];
        if (acc) begin
            if (lm == '0 && !members[src]) begin
                emit[0] = mk(is_cncl ? K_ACK : K_DATA, src, '0);
                ec      = EMIT_W'(1);
            end else begin
                mem_n = members | lm | sbit;
                rep_n = reported | sbit;
                if (is_cncl && !wvalid) begin
                    wv_n  = 1'b1;
                    wid_n = src;
                    if (qcnt != '0) begin
                        emit[0] = mk(K_XFR, src, q[0]);
                        emit[1] = mk(K_WAIT, q[0], src);
                        ec      = EMIT_W'(2);
                    end
                end else begin
                    if (qcnt != '0) begin
                        emit[0] = mk(K_XFR, pred, src);
                        emit[1] = mk(K_WAIT, src, pred);
                        ec      = EMIT_W'(2);
                    end else if (wvalid) begin
                        emit[0] = mk(K_XFR, wid, src);
                        emit[1] = mk(K_WAIT, src, wid);
                        ec      = EMIT_W'(2);
                    end
                    if (qcnt < CNT_W'(NODE_CNT)) begin
                        q_n[qcnt[ID_W-1:0]] = src;
                    end
                    qc_n = qcnt + 1'b1;
                end
                if (rep_n == mem_n) begin
                    if (!wv_n) begin
                        emit[ec[1:0]] = mk(K_DATA, q_n[0], '0);
                        ec            = ec + 1'b1;
                    end
                    mem_n = '0;
                    rep_n = '0;
                    wv_n  = 1'b0;
                    qc_n  = '0;
                end
            end
        end
        emit_cnt = ec;
    end

    // Register the conflict state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            members  <= '0;
            reported <= '0;
            wvalid   <= 1'b0;
            wid      <= '0;
            q        <= '0;
            qcnt     <= '0;
        end else begin
            members  <= mem_n;
            reported <= rep_n;
            wvalid   <= wv_n;
            wid      <= wid_n;
            q        <= q_n;
            qcnt     <= qc_n;
        end
    end

    // R5
    // reported_subset_chk
    reported_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reported & ~members) == '0);

    // R6
    // winner_member_chk
    winner_member_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid |-> members[wid]);

    // R8
    // loser_bound_chk
    loser_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qcnt <= CNT_W'(NODE_CNT - 1));

    // R10
    // open_has_report_chk
    open_has_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (members != '0) |-> (reported != '0));
endmodule

// File: rtl/hcs_out_fifo.sv
// In-order buffer for outgoing orders.
// Accepts up to MAX_EMIT entries per cycle and releases one per cycle.
// Assumes DEPTH is a power of two and the writer never pushes more
// entries than free_cnt allows.
module hcs_out_fifo
    import hcs_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  out_msg_t [MAX_EMIT-1:0]  push_msg,
    input  logic [EMIT_W-1:0]        push_cnt,
    input  logic                     pop,
    output out_msg_t                 head,
    output logic                     head_valid,
    output logic [$clog2(DEPTH+1)-1:0] free_cnt
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    out_msg_t          store [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;
    logic [CNT_W-1:0]  count;

    // Write the pushed entries into consecutive slots.
    always_ff @(posedge clk) begin
        for (int k = 0; k < int'(MAX_EMIT); k++) begin
            if (rst_n && EMIT_W'(k) < push_cnt) begin
                store[wptr + PTR_W'(k)] <= push_msg[k];
            end
        end
    end

    // Advance the pointers and the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            wptr  <= wptr + PTR_W'(push_cnt);
            rptr  <= rptr + PTR_W'(pop);
            count <= count + CNT_W'(push_cnt) - CNT_W'(pop);
        end
    end

    assign head       = store[rptr];
    assign head_valid = (count != '0);
    assign free_cnt   = CNT_W'(DEPTH) - count;

    // R12
    // no_overflow_chk
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(push_cnt) <= free_cnt);

    // R11
    // pop_nonempty_chk
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_valid);
endmodule

// File: rtl/hcs_mem_fetch.sv
// Single-word fetch buffer in front of a fixed-latency memory port.
// Starts a read on a speculative trigger or when a DATA order is waiting.
// Assumes the memory returns exactly one word per request.
module hcs_mem_fetch #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spec_req,
    input  logic              need,
    input  logic              consume,
    output logic              mem_rd_req,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              buf_valid,
    output logic [DATA_W-1:0] buf_data
);
    logic pending;
    logic issue;

    assign issue = (spec_req || need) && !pending && !buf_valid;

    // Track the outstanding request and the held word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_rd_req <= 1'b0;
            pending    <= 1'b0;
            buf_valid  <= 1'b0;
            buf_data   <= '0;
        end else begin
            mem_rd_req <= issue;
            if (issue) begin
                pending <= 1'b1;
            end else if (mem_rd_valid) begin
                pending <= 1'b0;
            end
            if (mem_rd_valid) begin
                buf_valid <= 1'b1;
                buf_data  <= mem_rd_data;
            end else if (consume) begin
                buf_valid <= 1'b0;
            end
        end
    end

    // R4
    // one_fetch_chk
    one_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);

    // R3
    // consume_held_chk
    consume_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> buf_valid);
endmodule

// File: rtl/home_conflict_sequencer.sv
// Home-side sequencer for one line in a four-node source-snoop fabric.
// Answers conflict-free READ/CNCL directly, chains conflicted parties
// into a forwarding order, and serialises orders over valid/ready.
// Assumes the memory port answers each request once, after fixed latency.
module home_conflict_sequencer
    import hcs_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned OUT_DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_seen,
    input  logic                 msg_valid,
    output logic                 msg_ready,
    input  logic                 msg_is_cncl,
    input  logic [ID_W-1:0]      msg_src,
    input  logic [NODE_CNT-1:0]  msg_conflicts,
    output logic                 mem_rd_req,
    input  logic                 mem_rd_valid,
    input  logic [DATA_W-1:0]    mem_rd_data,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [1:0]           out_kind,
    output logic [ID_W-1:0]      out_dst,
    output logic [ID_W-1:0]      out_peer,
    output logic [DATA_W-1:0]    out_data
);
    localparam int unsigned FCNT_W = $clog2(OUT_DEPTH + 1);

    out_msg_t [MAX_EMIT-1:0] emit;
    logic [EMIT_W-1:0]       emit_cnt;
    out_msg_t                head;
    logic                    head_valid;
    logic [FCNT_W-1:0]       free_cnt;
    logic                    acc, pop, head_is_data, need, buf_valid;
    logic [DATA_W-1:0]       buf_data;

    assign msg_ready    = free_cnt >= FCNT_W'(MAX_EMIT);
    assign acc          = msg_valid && msg_ready;
    assign head_is_data = head.kind == K_DATA;
    assign need         = head_valid && head_is_data && !buf_valid;
    assign out_valid    = head_valid && (!head_is_data || buf_valid);
    assign pop          = out_valid && out_ready;
    assign out_kind     = head.kind;
    assign out_dst      = head.dst;
    assign out_peer     = head.peer;
    assign out_data     = head_is_data ? buf_data : '0;

    hcs_episode u_episode (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .is_cncl  (msg_is_cncl),
        .src      (msg_src),
        .lst      (msg_conflicts),
        .emit     (emit),
        .emit_cnt (emit_cnt)
    );

    hcs_out_fifo #(.DEPTH(OUT_DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_msg   (emit),
        .push_cnt   (emit_cnt),
        .pop        (pop),
        .head       (head),
        .head_valid (head_valid),
        .free_cnt   (free_cnt)
    );

    hcs_mem_fetch #(.DATA_W(DATA_W)) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .spec_req     (req_seen),
        .need         (need),
        .consume      (pop && head_is_data),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .buf_valid    (buf_valid),
        .buf_data     (buf_data)
    );

    // R11
    // out_hold_chk
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_kind)
            && $stable(out_dst) && $stable(out_peer) && $stable(out_data)));

    // R3
    // data_word_chk
    data_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 2'd1) |-> buf_valid);
endmodule

// File: tb/home_conflict_sequencer_tb.sv
module home_conflict_sequencer_tb;
    localparam int DW      = 32;
    localparam int MEM_LAT = 12;
    localparam logic [DW-1:0] MEM_WORD = 32'hC0DE_5A17;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_seen = 1'b0, msg_valid = 1'b0, msg_is_cncl = 1'b0;
    logic [1:0] msg_src = '0;
    logic [3:0] msg_conflicts = '0;
    logic msg_ready, mem_rd_req, mem_rd_valid, out_valid;
    logic out_ready = 1'b0;
    logic [DW-1:0] mem_rd_data, out_data;
    logic [1:0] out_kind, out_dst, out_peer;

    home_conflict_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .req_seen(req_seen), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_is_cncl(msg_is_cncl), .msg_src(msg_src),
        .msg_conflicts(msg_conflicts), .mem_rd_req(mem_rd_req),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
        .out_dst(out_dst), .out_peer(out_peer), .out_data(out_data)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0, fetch_cnt = 0, rdy_pct = 100;
    int mem_cd = 0;
    int ek [4096], ed [4096], ep [4096];
    string etag [4096];
    int eh = 0, etl = 0;
    string tag_ovr = "";
    logic [3:0] m_mem = '0, m_rep = '0;
    bit m_wv = 0;
    int m_w = 0, m_qc = 0;
    int m_q [4];

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic push(int k, int d, int p, string tg);
        ek[etl] = k; ed[etl] = d; ep[etl] = p;
        etag[etl] = (tag_ovr != "") ? tag_ovr : tg;
        etl++;
    endtask

    // Expected orders, built from the requirements.
    task automatic model(bit c, int s, logic [3:0] l);
        logic [3:0] sb, lm;
        sb = 4'(1 << s);
        lm = l & ~sb;
        if (lm == 0 && !m_mem[s]) begin
            if (c) push(0, s, 0, "R2"); else push(1, s, 0, "R3");
        end else begin
            m_mem = m_mem | lm | sb;
            m_rep = m_rep | sb;
            if (c && !m_wv) begin
                m_wv = 1; m_w = s;
                if (m_qc > 0) begin push(2, s, m_q[0], "R6"); push(3, m_q[0], s, "R8"); end
            end else begin
                if (m_qc > 0) begin
                    push(2, m_q[m_qc-1], s, "R8"); push(3, s, m_q[m_qc-1], "R8");
                end else if (m_wv) begin
                    push(2, m_w, s, "R6"); push(3, s, m_w, "R8");
                end
                m_q[m_qc] = s; m_qc++;
            end
            if (m_rep == m_mem) begin
                if (!m_wv) push(1, m_q[0], 0, "R7");
                m_mem = '0; m_rep = '0; m_wv = 0; m_qc = 0;
            end
        end
    endtask

    task automatic send(bit c, int s, logic [3:0] l);
        @(negedge clk);
        while (!msg_ready) @(negedge clk);
        model(c, s, l);
        msg_valid = 1'b1; msg_is_cncl = c; msg_src = 2'(s); msg_conflicts = l;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic drain();
        while (eh != etl || out_valid) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Fixed-latency memory stub.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_cd <= 0; mem_rd_valid <= 1'b0;
        end else begin
            mem_rd_valid <= (mem_cd == 1);
            if (mem_rd_req) begin
                mem_cd <= MEM_LAT; fetch_cnt <= fetch_cnt + 1;
            end else if (mem_cd > 0) begin
                mem_cd <= mem_cd - 1;
            end
        end
    end
    assign mem_rd_data = MEM_WORD;

    // Output collector: random ready, order and hold checks.
    bit prev_stall = 0;
    logic [1:0] pk, pd, pp;
    logic [DW-1:0] pdat;
    always @(negedge clk) begin
        bit rdy;
        if (rst_n) begin
            rdy = ($urandom % 100) < rdy_pct;
            out_ready = rdy;
            if (prev_stall)
                check(out_valid && out_kind == pk && out_dst == pd && out_peer == pp
                      && out_data == pdat, "R11", "held order", int'(out_kind), int'(pk));
            if (out_valid && rdy) begin
                if (eh == etl) begin
                    check(0, "R11", "unexpected order kind", int'(out_kind), -1);
                end else begin
                    check(int'(out_kind) == ek[eh], etag[eh], "kind", int'(out_kind), ek[eh]);
                    check(int'(out_dst) == ed[eh], etag[eh], "dst", int'(out_dst), ed[eh]);
                    check(int'(out_peer) == ep[eh], etag[eh], "peer", int'(out_peer), ep[eh]);
                    if (ek[eh] == 1)
                        check(out_data == MEM_WORD, etag[eh], "data", int'(out_data), int'(MEM_WORD));
                    eh++;
                end
            end
            prev_stall = out_valid && !rdy;
            pk = out_kind; pd = out_dst; pp = out_peer; pdat = out_data;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(0, "R11", "watchdog expired, cycle", cyc, 150000);
            report();
        end
    end

    initial begin
        int f0;
        void'($urandom(32'd7741));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!out_valid, "R1", "out_valid", int'(out_valid), 0);
        check(!mem_rd_req, "R1", "mem_rd_req", int'(mem_rd_req), 0);
        check(msg_ready, "R1", "msg_ready", int'(msg_ready), 1);

        // R2 and R3 conflict-free answers
        send(1, 2, 4'b0000);
        send(0, 1, 4'b0000);
        drain();

        // R4 speculative fetch
        rdy_pct = 100;
        req_seen = 1'b1;
        @(negedge clk);
        req_seen = 1'b0;
        check(mem_rd_req, "R4", "speculative request", int'(mem_rd_req), 1);
        repeat (MEM_LAT + 6) @(negedge clk);
        f0 = fetch_cnt;
        send(0, 2, 4'b0000);
        #1;
        check(out_valid && out_kind == 2'd1, "R4", "DATA next cycle", int'(out_valid), 1);
        drain();
        check(fetch_cnt == f0, "R4", "extra fetches", fetch_cnt - f0, 0);

        // R5 node named by winner reports an empty vector
        send(1, 0, 4'b0100);
        tag_ovr = "R5";
        send(0, 2, 4'b0000);
        tag_ovr = "";
        drain();

        // R6 READ first, CNCL winner later
        send(0, 3, 4'b0010);
        send(1, 1, 4'b1000);
        drain();

        // R7 and R8 READ-only conflict of three
        send(0, 1, 4'b1100);
        send(0, 2, 4'b0000);
        send(0, 3, 4'b0010);
        drain();

        // R9 immediate answer, then R10 closure
        send(1, 0, 4'b1110);
        send(0, 1, 4'b0000);
        #1;
        check(out_valid && out_kind == 2'd2 && out_dst == 2'd0 && out_peer == 2'd1,
              "R9", "transfer before others report", int'(out_kind), 2);
        send(0, 2, 4'b0000);
        send(0, 3, 4'b0001);
        tag_ovr = "R10";
        send(1, 2, 4'b0000);
        send(0, 3, 4'b0000);
        tag_ovr = "";
        drain();

        // R12 backpressure fills the buffer
        rdy_pct = 0;
        for (int i = 0; i < 6; i++) send(1, i % 4, 4'b0000);
        @(negedge clk);
        check(!msg_ready, "R12", "msg_ready under full buffer", int'(msg_ready), 0);
        rdy_pct = 100;
        drain();

        // Random conflicts and conflict-free traffic
        rdy_pct = 60;
        for (int e = 0; e < 60; e++) begin
            logic [3:0] mask;
            int ord [4];
            int n, ci;
            do mask = 4'($urandom); while ($countones(mask) < 2);
            n = 0;
            for (int b = 0; b < 4; b++) if (mask[b]) begin ord[n] = b; n++; end
            for (int b = n - 1; b > 0; b--) begin
                int j, t;
                j = int'($urandom % (b + 1)); t = ord[b]; ord[b] = ord[j]; ord[j] = t;
            end
            ci = ($urandom % 3 == 0) ? -1 : int'($urandom % n);
            if ($urandom % 2 == 0) begin
                @(negedge clk); req_seen = 1'b1; @(negedge clk); req_seen = 1'b0;
            end
            for (int i = 0; i < n; i++) begin
                logic [3:0] own, lst;
                own = 4'(1 << ord[i]);
                lst = (i == 0) ? (mask & ~own) : (4'($urandom) & mask & ~own);
                send(i == ci, ord[i], lst);
            end
            if ($urandom % 2 == 0) send(1'($urandom), int'($urandom % 4), 4'b0000);
        end
        rdy_pct = 100;
        drain();
        check(eh == etl, "R12", "orders outstanding", etl - eh, 0);
        report();
    end
endmodule